// File: doc/BRIEF.md
# Priority-Masked Software Interrupt Pending Register

This block holds a 17-bit vector of pending software interrupts and turns it into a vector of posted interrupt requests by masking each bit against a 4-bit processor interrupt level. Software changes the pending vector through one of three write strobes: a whole-register load, an OR-in alias that sets the ones it is given, and an AND-NOT alias that clears the ones it is given. Two hardware match inputs, one per timer, set the lowest and the highest pending bit directly, so a timer compare can raise an interrupt without software involvement.

The level register is written through its own strobe. Requests are a pure function of the stored pending vector and the stored level, so a change to either appears on the request outputs in the same cycle that the register changes. The two timer bits follow a fixed rule (posted only while the level is below 14). The fifteen middle bits follow a per-bit rule (posted only when the bit number is above the level). Mapping a request to a trap number is left to the consumer.

Top module: `softint_top`

## Requirements
- R1: After reset the pending vector reads 0 and the level reads 15, so no request is posted.
- R2: The load, set and clear strobes are used one at a time; a load strobe replaces the pending vector with `wrData` on the next edge, and `pendingOut` reads the stored vector.
- R3: A set strobe ORs `wrData` into the pending vector on the next edge, leaving every bit where `wrData` is 0 unchanged.
- R4: A clear strobe clears every pending bit where `wrData` is 1 on the next edge and leaves the others unchanged.
- R5: For bit k from 1 to 15, `reqOut[k]` is 1 exactly when pending bit k is 1 and k is strictly greater than the level.
- R6: `reqOut[0]` and `reqOut[16]` are each 1 exactly when the matching pending bit is 1 and the level is below 14, whatever the level's relation to the bit number.
- R7: `hwMatch[1]` sets pending bit 16 and `hwMatch[0]` sets pending bit 0 on the next edge, and this set wins over a clear strobe or a load strobe aimed at the same bit in the same cycle.
- R8: A level write with `pilWrEn` stores `pilWrData` on the next edge, and `reqOut` is re-masked against the new level in that same cycle with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load strobe: replace the pending vector |
| setEn | input | 1 | Set strobe: OR `wrData` into the pending vector |
| clrEn | input | 1 | Clear strobe: clear pending bits where `wrData` is 1 |
| wrData | input | 17 | Data for the three software strobes |
| hwMatch | input | 2 | Timer match sets: bit 0 sets pending bit 0, bit 1 sets pending bit 16 |
| pilWrEn | input | 1 | Level write strobe |
| pilWrData | input | 4 | New interrupt level |
| pendingOut | output | 17 | Stored pending vector |
| pilOut | output | 4 | Stored interrupt level |
| reqOut | output | 17 | Posted interrupt requests after masking |

## Verification
A wrong pending bit shows on `pendingOut` one edge after the write or match that caused it. It also shows on `reqOut` in that same cycle whenever the level lets that bit through, so the level is swept across 0, 13, 14 and 15 to expose both masking rules. A mask error has no stored state and appears in the very cycle the level or pending vector changes. For that reason the bench compares every output against its behavioural model after every edge, including the cycles where a timer match collides with a clear or a load.

// File: rtl/softint_pkg.sv
package softint_pkg;
  localparam int VEC_W = 17;
  localparam int PIL_W = 4;
  localparam int LO_TIMER = 0;
  localparam int HI_TIMER = VEC_W - 1;
  localparam int TIMER_PIL_LIMIT = 14;
  localparam int PIL_RESET = 15;
  localparam int HW_W = 2;

  typedef struct packed {
    logic             load;
    logic [VEC_W-1:0] loadVal;
    logic [VEC_W-1:0] keepMask;
    logic [VEC_W-1:0] orMask;
    logic             pilLoad;
    logic [PIL_W-1:0] pilVal;
  } softint_strobe_t;
endpackage

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             setEn,
  input  logic             clrEn,
  input  logic [VEC_W-1:0] wrData,
  input  logic [HW_W-1:0]  hwMatch,
  input  logic             pilWrEn,
  input  logic [PIL_W-1:0] pilWrData,
  output softint_strobe_t  strobe
);
  logic [VEC_W-1:0] hwVec;

  // place each timer match onto its pending bit
  always_comb begin
    hwVec = '0;
    hwVec[LO_TIMER] = hwMatch[0];
    hwVec[HI_TIMER] = hwMatch[1];
  end

  always_comb begin
    strobe.load     = wrEn;
    strobe.loadVal  = wrData | hwVec;            // hardware set beats a load
    strobe.keepMask = clrEn ? ~wrData : '1;
    strobe.orMask   = (setEn ? wrData : '0) | hwVec; // and beats a clear
    strobe.pilLoad  = pilWrEn;
    strobe.pilVal   = pilWrData;
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, setEn, clrEn}));
endmodule

// File: rtl/softint_dp.sv
module softint_dp
  import softint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  softint_strobe_t  strobe,
  output logic [VEC_W-1:0] pendingOut,
  output logic [PIL_W-1:0] pilOut,
  output logic [VEC_W-1:0] reqOut
);
  logic [VEC_W-1:0] pendingQ;
  logic [PIL_W-1:0] pilQ;
  logic [VEC_W-1:0] pendingNext;

  always_comb begin
    if (strobe.load) pendingNext = strobe.loadVal;
    else             pendingNext = (pendingQ & strobe.keepMask) | strobe.orMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= '0;
      pilQ     <= PIL_W'(PIL_RESET);
    end else begin
      pendingQ <= pendingNext;
      if (strobe.pilLoad) pilQ <= strobe.pilVal;
    end
  end

  logic timerOpen;
  assign timerOpen = (pilQ < PIL_W'(TIMER_PIL_LIMIT));

  for (genvar k = 0; k < VEC_W; k++) begin : g_mask
    if (k == LO_TIMER || k == HI_TIMER) begin : g_timer
      assign reqOut[k] = pendingQ[k] & timerOpen;
    end else begin : g_level
      localparam logic [PIL_W:0] IDX = (PIL_W+1)'(k);
      assign reqOut[k] = pendingQ[k] & (IDX > {1'b0, pilQ});
      assert_level_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
        reqOut[k] |-> (k > int'(pilOut)));
    end
  end

  assign pendingOut = pendingQ;
  assign pilOut     = pilQ;

  assert_timer_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut[HI_TIMER] || reqOut[LO_TIMER]) |-> (int'(pilOut) < TIMER_PIL_LIMIT));
  assert_req_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut & ~pendingOut) == '0);
  assert_hw_hi_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.orMask[HI_TIMER] && !strobe.load |=> pendingOut[HI_TIMER]);
endmodule

// File: rtl/softint_top.sv
module softint_top
  import softint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             setEn,
  input  logic             clrEn,
  input  logic [VEC_W-1:0] wrData,
  input  logic [HW_W-1:0]  hwMatch,
  input  logic             pilWrEn,
  input  logic [PIL_W-1:0] pilWrData,
  output logic [VEC_W-1:0] pendingOut,
  output logic [PIL_W-1:0] pilOut,
  output logic [VEC_W-1:0] reqOut
);
  softint_strobe_t strobe;

  softint_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .setEn(setEn), .clrEn(clrEn),
    .wrData(wrData), .hwMatch(hwMatch), .pilWrEn(pilWrEn),
    .pilWrData(pilWrData), .strobe(strobe)
  );

  softint_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pendingOut(pendingOut), .pilOut(pilOut), .reqOut(reqOut)
  );

  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rstN)
    setEn |=> ((pendingOut & $past(wrData)) == $past(wrData)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrEn && !hwMatch[1] && wrData[HI_TIMER] |=> !pendingOut[HI_TIMER]);
  assert_hw_lo_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    hwMatch[0] |=> pendingOut[LO_TIMER]);
  assert_pil_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    pilWrEn |=> (pilOut == $past(pilWrData)));
endmodule

// File: tb/sim_softint_top.sv
module sim_softint_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 0, setEn = 0, clrEn = 0, pilWrEn = 0;
  logic [16:0] wrData = '0;
  logic [1:0]  hwMatch = '0;
  logic [3:0]  pilWrData = '0;
  logic [16:0] pendingOut, reqOut;
  logic [3:0]  pilOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  int mPend[17];
  int mPil;

  always #(CLK_PERIOD/2) clk = ~clk;

  softint_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .setEn(setEn), .clrEn(clrEn),
    .wrData(wrData), .hwMatch(hwMatch), .pilWrEn(pilWrEn),
    .pilWrData(pilWrData), .pendingOut(pendingOut), .pilOut(pilOut),
    .reqOut(reqOut)
  );

  function automatic logic [16:0] modelPend();
    logic [16:0] v;
    for (int i = 0; i < 17; i++) v[i] = (mPend[i] != 0);
    return v;
  endfunction

  function automatic logic [16:0] modelReq();
    logic [16:0] v;
    for (int i = 0; i < 17; i++) begin
      if (i == 0 || i == 16) v[i] = (mPend[i] != 0) && (mPil < 14);
      else                   v[i] = (mPend[i] != 0) && (i > mPil);
    end
    return v;
  endfunction

  task automatic compareAll(input string tag);
    checks++;
    if (pendingOut !== modelPend()) begin
      fails++;
      $display("FAIL %s pending actual=%h expected=%h", tag, pendingOut, modelPend());
    end
    checks++;
    if (int'(pilOut) != mPil) begin
      fails++;
      $display("FAIL %s R8 level actual=%0d expected=%0d", tag, pilOut, mPil);
    end
    checks++;
    if (reqOut !== modelReq()) begin
      fails++;
      $display("FAIL %s R5 R6 request actual=%h expected=%h", tag, reqOut, modelReq());
    end
  endtask

  // one cycle: drive, advance model, clock, compare
  task automatic step(input string tag, input bit w, input bit s, input bit c,
                      input logic [16:0] d, input logic [1:0] hw,
                      input bit pw, input int pv);
    int nxt[17];
    wrEn = w; setEn = s; clrEn = c; wrData = d; hwMatch = hw;
    pilWrEn = pw; pilWrData = 4'(pv);
    for (int i = 0; i < 17; i++) begin
      nxt[i] = mPend[i];
      if (w) nxt[i] = d[i];
      else if (s && d[i]) nxt[i] = 1;
      else if (c && d[i]) nxt[i] = 0;
    end
    if (hw[0]) nxt[0] = 1;
    if (hw[1]) nxt[16] = 1;
    @(posedge clk);
    mPend = nxt;
    if (pw) mPil = pv;
    @(negedge clk);
    wrEn = 0; setEn = 0; clrEn = 0; hwMatch = '0; pilWrEn = 0;
    compareAll(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 17; i++) mPend[i] = 0;
    mPil = 15;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 reset");

    // R2 load all ones with level 15: nothing posted
    step("R2 load", 1, 0, 0, 17'h1FFFF, 2'b00, 0, 0);
    // R6 R5 level sweep
    step("R6 level 14", 0, 0, 0, '0, 2'b00, 1, 14);
    step("R6 level 13", 0, 0, 0, '0, 2'b00, 1, 13);
    step("R5 level 0", 0, 0, 0, '0, 2'b00, 1, 0);
    step("R8 level 7", 0, 0, 0, '0, 2'b00, 1, 7);
    // R4 clear alias
    step("R4 clear", 0, 0, 1, 17'h0F0F1, 2'b00, 0, 0);
    step("R4 clear all", 0, 0, 1, 17'h1FFFF, 2'b00, 0, 0);
    // R3 set alias
    step("R3 set", 0, 1, 0, 17'h00210, 2'b00, 0, 0);
    step("R3 set more", 0, 1, 0, 17'h10003, 2'b00, 0, 0);
    // R7 hardware match versus clear and load
    step("R7 clear vs hw", 0, 0, 1, 17'h1FFFF, 2'b11, 0, 0);
    step("R7 load vs hw", 1, 0, 0, 17'h00000, 2'b10, 0, 0);
    step("R7 hw only lo", 0, 0, 0, '0, 2'b01, 1, 13);
    step("R8 level 15", 0, 0, 0, '0, 2'b00, 1, 15);

    // mixed pattern run
    for (int n = 0; n < 300; n++) begin
      int kind = $urandom_range(0, 3);
      logic [16:0] d = 17'($urandom);
      step("R2 R3 R4 R7 mix", kind == 1, kind == 2, kind == 3, d,
           2'($urandom_range(0, 3) == 0 ? $urandom : 0),
           $urandom_range(0, 3) == 0, $urandom_range(0, 15));
    end
    finishRun();
  end
endmodule